// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block fetches one instruction for a core that may execute 16-bit compressed instructions alongside 32-bit ones. A fetch request carries a byte address and a flag that enables compressed mode. The unit reads the 16-bit parcel at the address and the parcel two bytes above it from a byte-addressed memory. It looks at the two lowest bits of the first parcel to decide the instruction length. It returns the instruction right-aligned, together with a length flag that the program counter logic uses to step by 2 or by 4.

The unit checks alignment before it checks bounds. A fetch that fails either check returns an all-zero word, a single-cycle trap pulse and an instruction-specific trap code. The faulting address is kept in a bad-address output. The memory is read combinationally through two parcel ports that the unit drives. A parcel that does not lie wholly inside memory is never requested, and it reads as zero.

Top module: `ifetch_unit`

## Requirements
- R1: After reset, valid_o, trap_o, is_rvc_o, insn_o, trap_code_o and badvaddr_o are all zero.
- R2: When compressed mode is on (rvc_en_i=1), a fetch needs addr_i[0]=0. When it is off, a fetch needs addr_i[1:0]=0. A misaligned fetch traps with trap_code_o=0 (instruction address misaligned).
- R3: The fetch size is 2 bytes in compressed mode and 4 bytes otherwise. An aligned fetch with addr_i >= MEM_BYTES, or with addr_i + size > MEM_BYTES, computed without wrap-around, traps with trap_code_o=1 (instruction access fault). A fetch that is both misaligned and out of range reports code 0.
- R4: The low parcel is read at parcel index addr_i>>1 and the high parcel at (addr_i>>1)+1. Each read enable is high only during a request, and only when that parcel index is below MEM_BYTES/2. The data of a parcel that is not enabled is taken as zero, whatever the data input carries.
- R5: For a non-faulting fetch, if bits [1:0] of the low parcel are 2'b11, insn_o = {high parcel, low parcel} and is_rvc_o=0. Otherwise insn_o = {16'h0000, low parcel} and is_rvc_o=1.
- R6: Results appear on the clock edge that samples req_i. valid_o (no fault) and trap_o (fault) are single-cycle pulses and are never high together. Without a request, insn_o and is_rvc_o hold their values.
- R7: A faulting fetch sets insn_o to zero and is_rvc_o to 0, and loads its address into badvaddr_o. badvaddr_o holds that value until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request, one per cycle |
| addr_i | input | ADDR_W | Fetch byte address |
| rvc_en_i | input | 1 | Compressed mode enable |
| lo_rd_en_o | output | 1 | Low parcel read enable |
| lo_addr_o | output | ADDR_W-1 | Low parcel index |
| lo_data_i | input | 16 | Low parcel read data |
| hi_rd_en_o | output | 1 | High parcel read enable |
| hi_addr_o | output | ADDR_W-1 | High parcel index |
| hi_data_i | input | 16 | High parcel read data |
| valid_o | output | 1 | Instruction valid pulse |
| insn_o | output | 32 | Instruction word, right-aligned |
| is_rvc_o | output | 1 | 1 when the instruction is 16 bits long |
| trap_o | output | 1 | Fetch fault pulse |
| trap_code_o | output | 4 | Trap code: 0 misaligned, 1 access fault |
| badvaddr_o | output | ADDR_W | Address of the last faulting fetch |

## Verification
A wrong alignment or bounds decision shows one cycle after the request: trap_o or valid_o takes the opposite value, or the trap code is wrong. The sweep covers every address across the memory and a few bytes past its end, in both modes. A wrong high-parcel mask or a wrong length decision corrupts insn_o[31:16] or is_rvc_o on that same cycle. The bench memory drives all-ones junk on any port that is not enabled, so a missing mask shows up at once. A read enable asserted past the end of memory is seen combinationally during the request cycle. A badvaddr_o register that fails to hold shows at the next fault check.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int PARCEL_W = 16;
  localparam int INSN_W   = 32;

  typedef enum logic [3:0] {
    TRAP_FETCH_MISALIGN = 4'd0,
    TRAP_FETCH_ACCESS   = 4'd1
  } trap_code_e;
endpackage

// File: rtl/ifu_fault_chk.sv
module ifu_fault_chk
  import ifu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rvc_en_i,
  output logic              fault_o,
  output trap_code_e        code_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

  logic            misalign;
  logic            out_of_range;
  logic [ADDR_W:0] start_w;
  logic [ADDR_W:0] end_w;

  always_comb begin
    misalign     = rvc_en_i ? addr_i[0] : |addr_i[1:0];
    start_w      = {1'b0, addr_i};
    end_w        = start_w + (rvc_en_i ? (ADDR_W+1)'(2) : (ADDR_W+1)'(4));
    out_of_range = (start_w >= LIMIT) || (end_w > LIMIT);
    fault_o      = misalign || out_of_range;
    // alignment takes precedence over bounds
    code_o       = misalign ? TRAP_FETCH_MISALIGN : TRAP_FETCH_ACCESS;
  end
endmodule

// File: rtl/ifu_parcel_fetch.sv
module ifu_parcel_fetch
  import ifu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 64
) (
  input  logic                req_i,
  input  logic [ADDR_W-2:0]   pidx_i,
  output logic                lo_rd_en_o,
  output logic [ADDR_W-2:0]   lo_addr_o,
  input  logic [PARCEL_W-1:0] lo_data_i,
  output logic                hi_rd_en_o,
  output logic [ADDR_W-2:0]   hi_addr_o,
  input  logic [PARCEL_W-1:0] hi_data_i,
  output logic [PARCEL_W-1:0] lo_o,
  output logic [PARCEL_W-1:0] hi_o
);
  localparam int              PA_W        = ADDR_W - 1;
  localparam int              NUM_PARCELS = MEM_BYTES / 2;
  localparam logic [PA_W:0]   NP_W        = (PA_W+1)'(NUM_PARCELS);

  logic [PA_W-1:0]     idx   [2];
  logic                rd_en [2];
  logic [PARCEL_W-1:0] din   [2];
  logic [PARCEL_W-1:0] dout  [2];

  assign din[0] = lo_data_i;
  assign din[1] = hi_data_i;

  for (genvar g = 0; g < 2; g++) begin : g_parcel
    logic [PA_W:0] idx_w;
    always_comb begin
      // one extra bit so the high index cannot wrap back into memory
      idx_w    = {1'b0, pidx_i} + (PA_W+1)'(g);
      idx[g]   = idx_w[PA_W-1:0];
      rd_en[g] = req_i && (idx_w < NP_W);
      dout[g]  = rd_en[g] ? din[g] : '0;
    end
  end

  assign lo_addr_o  = idx[0];
  assign hi_addr_o  = idx[1];
  assign lo_rd_en_o = rd_en[0];
  assign hi_rd_en_o = rd_en[1];
  assign lo_o       = dout[0];
  assign hi_o       = dout[1];
endmodule

// File: rtl/ifu_assemble.sv
module ifu_assemble
  import ifu_pkg::*;
(
  input  logic [PARCEL_W-1:0] lo_i,
  input  logic [PARCEL_W-1:0] hi_i,
  output logic [INSN_W-1:0]   insn_o,
  output logic                is_rvc_o
);
  always_comb begin
    is_rvc_o = (lo_i[1:0] != 2'b11);
    insn_o   = is_rvc_o ? {{(INSN_W-PARCEL_W){1'b0}}, lo_i} : {hi_i, lo_i};
  end
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rvc_en_i,
  output logic                lo_rd_en_o,
  output logic [ADDR_W-2:0]   lo_addr_o,
  input  logic [PARCEL_W-1:0] lo_data_i,
  output logic                hi_rd_en_o,
  output logic [ADDR_W-2:0]   hi_addr_o,
  input  logic [PARCEL_W-1:0] hi_data_i,
  output logic                valid_o,
  output logic [INSN_W-1:0]   insn_o,
  output logic                is_rvc_o,
  output logic                trap_o,
  output logic [3:0]          trap_code_o,
  output logic [ADDR_W-1:0]   badvaddr_o
);
  logic                fault;
  trap_code_e          code;
  logic [PARCEL_W-1:0] lo_par;
  logic [PARCEL_W-1:0] hi_par;
  logic [INSN_W-1:0]   insn_d;
  logic                is_rvc_d;

  ifu_fault_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_fault (
    .addr_i   (addr_i),
    .rvc_en_i (rvc_en_i),
    .fault_o  (fault),
    .code_o   (code)
  );

  ifu_parcel_fetch #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_parcel (
    .req_i      (req_i),
    .pidx_i     (addr_i[ADDR_W-1:1]),
    .lo_rd_en_o (lo_rd_en_o),
    .lo_addr_o  (lo_addr_o),
    .lo_data_i  (lo_data_i),
    .hi_rd_en_o (hi_rd_en_o),
    .hi_addr_o  (hi_addr_o),
    .hi_data_i  (hi_data_i),
    .lo_o       (lo_par),
    .hi_o       (hi_par)
  );

  ifu_assemble u_asm (
    .lo_i     (lo_par),
    .hi_i     (hi_par),
    .insn_o   (insn_d),
    .is_rvc_o (is_rvc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      trap_o      <= 1'b0;
      insn_o      <= '0;
      is_rvc_o    <= 1'b0;
      trap_code_o <= '0;
      badvaddr_o  <= '0;
    end else begin
      valid_o <= req_i && !fault;
      trap_o  <= req_i && fault;
      if (req_i) begin
        insn_o   <= fault ? '0 : insn_d;
        is_rvc_o <= !fault && is_rvc_d;
        if (fault) begin
          trap_code_o <= code;
          badvaddr_o  <= addr_i;
        end
      end
    end
  end
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              hi_rd_en_o,
  input logic              lo_rd_en_o,
  input logic [ADDR_W-2:0] hi_addr_o,
  input logic              valid_o,
  input logic [31:0]       insn_o,
  input logic              is_rvc_o,
  input logic              trap_o,
  input logic [ADDR_W-1:0] badvaddr_o
);
  localparam int NUM_PARCELS = MEM_BYTES / 2;

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && trap_o));

  assert_valid_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o && !trap_o);

  assert_trap_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> insn_o == 32'h0 && !is_rvc_o);

  assert_bad_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> trap_o |-> badvaddr_o == $past(addr_i));

  assert_long_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !is_rvc_o |-> insn_o[1:0] == 2'b11);

  assert_short_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && is_rvc_o |-> insn_o[31:16] == 16'h0 && insn_o[1:0] != 2'b11);

  assert_hi_in_mem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd_en_o |-> int'(hi_addr_o) < NUM_PARCELS);

  assert_rd_only_on_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd_en_o || hi_rd_en_o) |-> req_i);
endmodule

bind ifetch_unit ifu_fetch_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_fetch_chk (.*);

// File: tb/ifetch_unit_tb_top.sv
module ifetch_unit_tb_top;
  localparam int ADDR_W    = 16;
  localparam int MEM_BYTES = 64;
  localparam int NP        = MEM_BYTES / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rvc = 1'b0;
  logic              lo_en, hi_en;
  logic [ADDR_W-2:0] lo_a, hi_a;
  logic [15:0]       lo_d, hi_d;
  logic              valid, is_rvc, trap;
  logic [31:0]       insn;
  logic [3:0]        code;
  logic [ADDR_W-1:0] bad;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] exp_bad = '0;

  always #10 clk = ~clk;

  function automatic logic [15:0] pv(int p);
    logic [15:0] v;
    v = 16'(p * 40503 + 7);
    return {v[15:2], 2'(p ^ (p >> 2))};
  endfunction

  always_comb lo_d = (lo_en && int'(lo_a) < NP) ? pv(int'(lo_a)) : 16'hFFFF;
  always_comb hi_d = (hi_en && int'(hi_a) < NP) ? pv(int'(hi_a)) : 16'hFFFF;

  ifetch_unit #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .rvc_en_i(rvc),
    .lo_rd_en_o(lo_en), .lo_addr_o(lo_a), .lo_data_i(lo_d),
    .hi_rd_en_o(hi_en), .hi_addr_o(hi_a), .hi_data_i(hi_d),
    .valid_o(valid), .insn_o(insn), .is_rvc_o(is_rvc), .trap_o(trap),
    .trap_code_o(code), .badvaddr_o(bad)
  );

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h rvc=%0d act=%0h exp=%0h", req_tag, addr, rvc, act, exp);
    end
  endtask

  task automatic fetch(int a, bit r);
    int  sz, pi;
    bit  mis, oob, flt;
    logic [15:0] lo, hi;
    logic [31:0] e_insn;
    bit  e_rvc;
    @(negedge clk);
    req = 1'b1; addr = ADDR_W'(a); rvc = r;
    sz  = r ? 2 : 4;
    mis = r ? (a % 2 != 0) : (a % 4 != 0);
    oob = (a >= MEM_BYTES) || (a + sz > MEM_BYTES);
    flt = mis || oob;
    pi  = a / 2;
    #1;
    chk("R4 lo_en", 64'(lo_en), 64'(pi < NP));
    chk("R4 hi_en", 64'(hi_en), 64'(pi + 1 < NP));
    if (pi < NP) chk("R4 lo_addr", 64'(lo_a), 64'(pi));
    lo = (pi < NP) ? pv(pi) : 16'h0;
    hi = (pi + 1 < NP) ? pv(pi + 1) : 16'h0;
    if (lo[1:0] == 2'b11) begin e_insn = {hi, lo}; e_rvc = 1'b0; end
    else begin e_insn = {16'h0, lo}; e_rvc = 1'b1; end
    if (flt) begin e_insn = '0; e_rvc = 1'b0; exp_bad = ADDR_W'(a); end
    @(negedge clk);
    req = 1'b0;
    chk("R6 valid", 64'(valid), 64'(!flt));
    chk(mis ? "R2 trap" : "R3 trap", 64'(trap), 64'(flt));
    chk("R5 insn", 64'(insn), 64'(e_insn));
    chk("R5 is_rvc", 64'(is_rvc), 64'(e_rvc));
    if (flt) chk(mis ? "R2 code" : "R3 code", 64'(code), mis ? 64'd0 : 64'd1);
    chk("R7 badvaddr", 64'(bad), 64'(exp_bad));
    @(negedge clk);
    chk("R6 pulse", 64'({valid, trap}), 64'd0);
    chk("R6 hold", 64'({is_rvc, insn}), 64'({e_rvc, e_insn}));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35;
    chk("R1 reset", 64'({valid, trap, is_rvc, insn, code, bad}), 64'd0);
    rst_n = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < MEM_BYTES + 6; a++) fetch(a, bit'(r));
      fetch(16'hFFFC, bit'(r));
      fetch(16'hFFFE, bit'(r));
      fetch(16'hFFFF, bit'(r));
    end
    // back-to-back fault then good fetch keeps badvaddr
    fetch(3, 1'b0);
    fetch(8, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule